// File: doc/BRIEF.md
# Serial Control Word Receiver

This block is the slave side of a write-only serial link that loads a five-bit control word from a host. The word carries a three-bit channel address, a conversion-request bit and a standby bit. The host pulls an active-low frame strobe low and supplies a serial clock. Data bits are taken on falling clock edges. All three serial inputs are asynchronous to the system clock, so they are resynchronised and oversampled before any decision is made.

Bits arrive in the fixed order: channel bit 2, channel bit 1, channel bit 0, conversion request, standby. They are assembled in a private shift register. The live control register is loaded only on the sixth falling edge of the frame, so a partly received word never shows at the outputs. A frame that stops before the sixth edge changes nothing. Edges after the sixth are ignored. A set conversion-request bit in the committed word produces a single-cycle start strobe.

Top module: `sctl_rx`

## Requirements
- R1: While reset is asserted and right after it, `chanSel` is 0, `standby` is 0 and `convStart` is 0.
- R2: The first sampled bit of a frame lands in `chanSel[2]`, the second in `chanSel[1]`, the third in `chanSel[0]`, the fourth is the conversion request and the fifth drives `standby`.
- R3: Each bit is the value of `sdIn` at the SCLK falling edge. A change of `sdIn` while SCLK is low, before the next rise, does not alter the captured bit.
- R4: Falling edges seven and later within one frame, and the data on the sixth and later edges, have no effect on the outputs.
- R5: The outputs keep their old value through the fifth falling edge. They take the new word within four system clocks of the sixth falling edge.
- R6: A frame with fewer than six falling edges leaves `chanSel`, `standby` and `convStart` unchanged.
- R7: `convStart` is high for exactly one system clock per committed word whose conversion bit is 1. It stays low when that bit is 0, whatever the frame length.
- R8: Raising the frame strobe clears the edge count, so the next frame is decoded from its own first edge.
- R9: SCLK falling edges seen while the frame strobe is high are ignored. This includes an edge whose transition coincides with the strobe's rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rstN | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | Serial clock from the host, idle high |
| frameN | input | 1 | Active-low write frame strobe |
| sdIn | input | 1 | Serial data from the host |
| chanSel | output | 3 | Committed channel address |
| standby | output | 1 | Committed standby level |
| convStart | output | 1 | One-clock conversion start strobe |

## Verification
The commit on the sixth falling edge and the end of a frame can land in the same resynchronised cycle when the host raises the strobe at the same instant it drops SCLK for the sixth time. The bench drives both transitions in one statement. It then expects the register and the strobe count to be untouched, because the edge is judged against the already-inactive strobe. A following normal frame must still load, which shows that the aborted frame left no residual count.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic commit;
  } strobe_t;

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stageQ[s] <= RESET_VAL;
        end else begin
          if (s == 0) stageQ[s] <= asyncIn;
          else        stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/sctl_ctrl.sv
module sctl_ctrl
  import sctl_pkg::*;
#(
  parameter int WORD_BITS = 5,
  parameter int COMMIT_EDGE = 6
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkS,
  input  logic    frameS,
  output strobe_t stb
);

  localparam int CNT_W = $clog2(COMMIT_EDGE + 1);
  localparam logic [CNT_W-1:0] WORD_CNT = CNT_W'(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(COMMIT_EDGE - 1);
  localparam logic [CNT_W-1:0] SAT_CNT  = CNT_W'(COMMIT_EDGE);

  logic             sclkPrev;
  logic [CNT_W-1:0] bitCnt;
  logic             fallSeen;
  logic             frameActive;

  assign fallSeen    = sclkPrev & ~sclkS;
  assign frameActive = ~frameS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b1;
      bitCnt   <= '0;
    end else begin
      sclkPrev <= sclkS;
      if (frameS)
        bitCnt <= '0;
      else if (fallSeen && bitCnt < SAT_CNT)
        bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    stb.shiftEn = frameActive & fallSeen & (bitCnt < WORD_CNT);
    stb.commit  = frameActive & fallSeen & (bitCnt == LAST_CNT);
  end

  // R4
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= SAT_CNT);

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameS |=> (bitCnt == '0));

endmodule

// File: rtl/sctl_dp.sv
module sctl_dp
  import sctl_pkg::*;
#(
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdS,
  input  strobe_t           stb,
  output logic [CHAN_W-1:0] chanSel,
  output logic              standby,
  output logic              convStart
);

  localparam int WORD_BITS = CHAN_W + 2;
  localparam int STBY_POS  = 0;
  localparam int CONV_POS  = 1;
  localparam int CHAN_LO   = 2;

  logic [WORD_BITS-1:0] shiftReg;
  logic [WORD_BITS-1:0] liveReg;
  logic                 convPulse;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      liveReg   <= '0;
      convPulse <= 1'b0;
    end else begin
      if (stb.shiftEn) shiftReg <= {shiftReg[WORD_BITS-2:0], sdS};
      if (stb.commit)  liveReg  <= shiftReg;
      convPulse <= stb.commit & shiftReg[CONV_POS];
    end
  end

  assign chanSel   = liveReg[CHAN_LO +: CHAN_W];
  assign standby   = liveReg[STBY_POS];
  assign convStart = convPulse;

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftEn |-> !stb.commit);

  // R7
  conv_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

endmodule

// File: rtl/sctl_rx.sv
module sctl_rx
  import sctl_pkg::*;
#(
  parameter int CHAN_W = 3,
  parameter int SYNC_STAGES = 2,
  parameter int COMMIT_EDGE = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              frameN,
  input  logic              sdIn,
  output logic [CHAN_W-1:0] chanSel,
  output logic              standby,
  output logic              convStart
);

  localparam int WORD_BITS = CHAN_W + 2;

  logic [2:0] syncBus;
  strobe_t    stb;

  sctl_sync #(
    .WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b110)
  ) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({sclkIn, frameN, sdIn}),
    .syncOut(syncBus)
  );

  sctl_ctrl #(
    .WORD_BITS(WORD_BITS), .COMMIT_EDGE(COMMIT_EDGE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .sclkS(syncBus[2]), .frameS(syncBus[1]),
    .stb(stb)
  );

  sctl_dp #(
    .CHAN_W(CHAN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .sdS(syncBus[0]), .stb(stb),
    .chanSel(chanSel), .standby(standby), .convStart(convStart)
  );

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncBus[1] |=> ($stable(chanSel) && $stable(standby) && !convStart));

endmodule

// File: tb/sctl_rx_tb.sv
module sctl_rx_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclkIn = 1'b1;
  logic       frameN = 1'b1;
  logic       sdIn = 1'b0;
  logic [2:0] chanSel;
  logic       standby;
  logic       convStart;

  int nChk = 0;
  int nBad = 0;
  int pulses = 0;
  int pulseBase = 0;

  sctl_rx u_dut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .frameN(frameN), .sdIn(sdIn),
    .chanSel(chanSel), .standby(standby), .convStart(convStart)
  );

  always #2 clk = ~clk;

  always @(negedge clk) if (rstN && convStart) pulses++;

  // {edges[4:0], bits[15:0] first bit at MSB, expChan[2:0], expStby, expPulse}
  localparam logic [25:0] VEC [8] = '{
    {5'd6,  16'hA800, 3'd5, 1'b1, 1'b0},
    {5'd16, 16'h77FF, 3'd3, 1'b0, 1'b1},
    {5'd5,  16'hF800, 3'd3, 1'b0, 1'b0},
    {5'd8,  16'hCF00, 3'd6, 1'b1, 1'b0},
    {5'd6,  16'h1000, 3'd0, 1'b0, 1'b1},
    {5'd3,  16'hE000, 3'd0, 1'b0, 1'b0},
    {5'd7,  16'h5C00, 3'd2, 1'b1, 1'b1},
    {5'd0,  16'hFFFF, 3'd2, 1'b1, 1'b0}
  };

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] expCh,
                       input logic expSt, input int expPl);
    int got;
    got = pulses - pulseBase;
    nChk++;
    if (chanSel !== expCh || standby !== expSt || got != expPl) begin
      nBad++;
      $display("FAIL %s: chanSel=%0d standby=%0b pulses=%0d expected chanSel=%0d standby=%0b pulses=%0d",
               req, chanSel, standby, got, expCh, expSt, expPl);
    end
  endtask

  task automatic clockBit(input logic b, input bit flip);
    sdIn = b;
    waitClk(2);
    sclkIn = 1'b0;
    waitClk(1);
    if (flip) sdIn = ~b;
    waitClk(3);
    sclkIn = 1'b1;
    waitClk(2);
  endtask

  task automatic sendFrame(input int n, input logic [15:0] bits, input bit flip);
    pulseBase = pulses;
    frameN = 1'b0;
    waitClk(4);
    for (int i = 0; i < n; i++) clockBit(bits[15-i], flip);
    waitClk(2);
    frameN = 1'b1;
    waitClk(6);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    waitClk(5);
    nChk++;
    if (chanSel !== 3'd0 || standby !== 1'b0 || convStart !== 1'b0) begin
      nBad++;
      $display("FAIL R1: outputs %0d %0b %0b expected 0 0 0", chanSel, standby, convStart);
    end
    rstN = 1'b1;
    waitClk(4);
    pulseBase = pulses;
    check("R1", 3'd0, 1'b0, 0);

    // table: R2 order, R4 extra edges, R6 short frames, R7 pulses, R8 abort
    for (int v = 0; v < 8; v++) begin
      sendFrame(int'(VEC[v][25:21]), VEC[v][20:5], 1'b0);
      check($sformatf("R2/R4/R6/R7 vector %0d", v),
            VEC[v][4:2], VEC[v][1], int'(VEC[v][0]));
    end

    // R3: data flips while SCLK low; bits 1,1,0,0,1 then 0
    sendFrame(6, 16'hC800, 1'b1);
    check("R3", 3'd6, 1'b1, 0);

    // R5: no change after fifth edge, new word after sixth
    pulseBase = pulses;
    frameN = 1'b0;
    waitClk(4);
    clockBit(1'b1, 1'b0);
    clockBit(1'b1, 1'b0);
    clockBit(1'b1, 1'b0);
    clockBit(1'b1, 1'b0);
    clockBit(1'b0, 1'b0);
    waitClk(4);
    check("R5 after fifth edge", 3'd6, 1'b1, 0);
    clockBit(1'b0, 1'b0);
    waitClk(2);
    check("R5 after sixth edge", 3'd7, 1'b0, 1);
    frameN = 1'b1;
    waitClk(6);

    // R9: sixth edge coincides with strobe rise
    pulseBase = pulses;
    frameN = 1'b0;
    waitClk(4);
    clockBit(1'b0, 1'b0);
    clockBit(1'b0, 1'b0);
    clockBit(1'b1, 1'b0);
    clockBit(1'b1, 1'b0);
    clockBit(1'b1, 1'b0);
    sdIn = 1'b0;
    waitClk(2);
    sclkIn = 1'b0;
    frameN = 1'b1;
    waitClk(6);
    sclkIn = 1'b1;
    waitClk(4);
    check("R9 coincident edge", 3'd7, 1'b0, 0);

    // R9: edges while strobe idle
    for (int k = 0; k < 8; k++) clockBit(k[0], 1'b0);
    waitClk(4);
    check("R9 idle edges", 3'd7, 1'b0, 0);

    // R8: aborted frame then a full frame bits 0,1,0,1,0
    pulseBase = pulses;
    frameN = 1'b0;
    waitClk(4);
    clockBit(1'b1, 1'b0);
    clockBit(1'b1, 1'b0);
    frameN = 1'b1;
    waitClk(6);
    check("R8 aborted frame", 3'd7, 1'b0, 0);
    sendFrame(6, 16'h5000, 1'b0);
    check("R8 following frame", 3'd2, 1'b0, 1);

    // R1 reset mid-run returns to zero
    rstN = 1'b0;
    waitClk(3);
    rstN = 1'b1;
    waitClk(3);
    pulseBase = pulses;
    check("R1 re-reset", 3'd0, 1'b0, 0);

    summary();
    $finish;
  end

endmodule